// File: doc/BRIEF.md
# Peripheral Interrupt Request Controller

This block collects interrupt requests from a network controller and a SCSI processor and presents them to the host processor as a single prioritized request level plus a pending flag. There are three sources. A rising edge on the network controller's interrupt pin marks normal completion. A one-cycle bus-error pulse from that controller's bus interface marks a faulted bus operation. The SCSI processor's active-low request pin is followed as a live level. Each source has its own control register, which holds an enable bit and a 3-bit request level.

Software reaches the three control registers through a small register-mapped slave port. The two latched sources (network completion and network bus error) each keep a status bit, which software clears by writing 1 to it. The block also decodes the host address bus and raises a chip select for the SCSI processor's 4 KB register window at 0xFFF47000. Vector generation and the acknowledge cycle are handled elsewhere.

Top module: `periph_irq_ctrl`

## Requirements
- R1: After reset every control register reads 0x00, `irq_pend` is 0 and `irq_level` is 0.
- R2: Register index 0 controls network completion, 1 controls network bus error and 2 controls the SCSI request. In each register, bits [2:0] are the level and bit 4 is the enable. A write stores both fields, and a read returns them in the same positions. Bits 3, 6 and 7 read 0, and index 3 reads 0x00.
- R3: `net_int` passes through a two-flop synchronizer. A low-to-high change sets bit 5 of register 0 at the third rising clock edge after the change. Holding the pin high, or driving it low, does not set the bit again.
- R4: Writing a register with bit 5 set clears that register's status bit. Writing with bit 5 clear leaves the status bit unchanged.
- R5: A `net_berr` pulse sampled high at a clock edge sets bit 5 of register 1 at that edge. The bit then stays set until software clears it.
- R6: Bit 5 of register 2 reads 1 while the synchronized `scsi_irq_n` is low, starting at the second clock edge after the pin falls. It is not latched, and it follows the pin back high.
- R7: Status bits record events whether or not the source is enabled. A source takes part in the request only when its enable bit is set.
- R8: `irq_level` is the highest level among the sources that are enabled, active and have a nonzero level. A level of 0 never requests. `irq_pend` is 1 exactly when `irq_level` is nonzero.
- R9: `scsi_cs` is 1 exactly when `bus_strobe` is 1 and `bus_addr[31:12]` equals 0xFFF47.
- R10: If a status-clearing write and a new event for the same source land in the same cycle, the status ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | Write qualifier for the register access |
| reg_addr | input | 2 | Control register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the register at `reg_addr` |
| net_int | input | 1 | Network controller interrupt pin (asynchronous, rising edge) |
| net_berr | input | 1 | Network bus-error pulse (synchronous, one cycle) |
| scsi_irq_n | input | 1 | SCSI processor request pin (asynchronous, active low) |
| bus_strobe | input | 1 | Host address valid |
| bus_addr | input | 32 | Host address |
| scsi_cs | output | 1 | SCSI processor window select |
| irq_level | output | 3 | Highest active request level |
| irq_pend | output | 1 | A request is pending |

## Verification
The assertions assume that `net_berr` is a clean synchronous pulse sampled at clock edges. They also assume that the register port is stable across each edge. Nothing is assumed about the two asynchronous pins beyond the synchronizer delay. The stimulus meets these assumptions by driving every input at the falling clock edge. It holds each pin level for at least three cycles before it reads status or checks the request level, and it never leaves the bus-error line high for more than one cycle except in the deliberate set-versus-clear case.

// File: rtl/periph_irq_ctrl.sv
module periph_irq_ctrl #(
  parameter int          LW        = 3,
  parameter int          DW        = 8,
  parameter int          AW        = 32,
  parameter int          RA        = 2,
  parameter logic [31:0] SCSI_BASE = 32'hFFF4_7000,
  parameter int          WIN       = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [RA-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          net_int,
  input  logic          net_berr,
  input  logic          scsi_irq_n,
  input  logic          bus_strobe,
  input  logic [AW-1:0] bus_addr,
  output logic          scsi_cs,
  output logic [LW-1:0] irq_level,
  output logic          irq_pend
);
  localparam int NSRC   = 3;
  localparam int EN_BIT = 4;
  localparam int ST_BIT = 5;

  logic [LW-1:0] lvl [NSRC];
  logic [NSRC-1:0] en;
  logic stat_net, stat_berr;
  logic n_s1, n_s2, n_s3, s_s1, s_s2;
  logic [NSRC-1:0] wr_hit, src, act;
  logic net_rise, scsi_on;

  always_comb
    for (int i = 0; i < NSRC; i++)
      wr_hit[i] = reg_sel && reg_wr && (reg_addr == RA'(i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {n_s1, n_s2, n_s3} <= '0;
      {s_s1, s_s2}       <= 2'b11;
    end else begin
      {n_s1, n_s2, n_s3} <= {net_int, n_s1, n_s2};
      {s_s1, s_s2}       <= {scsi_irq_n, s_s1};
    end
  end

  assign net_rise = n_s2 && !n_s3;
  assign scsi_on  = !s_s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= '0;
      for (int i = 0; i < NSRC; i++) lvl[i] <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++)
        if (wr_hit[i]) begin
          lvl[i] <= reg_wdata[LW-1:0];
          en[i]  <= reg_wdata[EN_BIT];
        end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_net  <= 1'b0;
      stat_berr <= 1'b0;
    end else begin
      if (net_rise)                         stat_net <= 1'b1;
      else if (wr_hit[0] && reg_wdata[ST_BIT]) stat_net <= 1'b0;
      if (net_berr)                         stat_berr <= 1'b1;
      else if (wr_hit[1] && reg_wdata[ST_BIT]) stat_berr <= 1'b0;
    end
  end

  assign src = {scsi_on, stat_berr, stat_net};

  always_comb begin
    irq_level = '0;
    for (int i = 0; i < NSRC; i++) begin
      act[i] = en[i] && src[i] && (lvl[i] != '0);
      if (act[i] && lvl[i] > irq_level) irq_level = lvl[i];
    end
  end

  assign irq_pend = |act;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NSRC; i++)
      if (reg_addr == RA'(i)) begin
        reg_rdata[LW-1:0]  = lvl[i];
        reg_rdata[EN_BIT]  = en[i];
        reg_rdata[ST_BIT]  = src[i];
      end
  end

  assign scsi_cs = bus_strobe && (bus_addr[AW-1:WIN] == SCSI_BASE[AW-1:WIN]);
endmodule

module periph_irq_ctrl_chk #(
  parameter int LW = 3,
  parameter int RA = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_sel,
  input logic          reg_wr,
  input logic [RA-1:0] reg_addr,
  input logic [7:0]    reg_wdata,
  input logic          net_berr,
  input logic          bus_strobe,
  input logic          scsi_cs,
  input logic [LW-1:0] irq_level,
  input logic          irq_pend,
  input logic [2:0]    en_v,
  input logic [LW-1:0] berr_lvl,
  input logic          berr_stat
);
  logic berr_wr;
  assign berr_wr = reg_sel && reg_wr && (reg_addr == RA'(1));

  // R5
  berr_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    net_berr && en_v[1] && berr_lvl != '0 && !berr_wr |=> irq_pend && irq_level >= $past(berr_lvl));

  // R7
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_v == 3'b000 |-> !irq_pend);

  // R8
  pend_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend == (irq_level != '0));

  // R9
  cs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scsi_cs |-> bus_strobe);

  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    berr_stat && !(berr_wr && reg_wdata[5]) |=> berr_stat);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    net_berr |=> berr_stat);
endmodule

bind periph_irq_ctrl periph_irq_ctrl_chk #(.LW(LW), .RA(RA)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .net_berr(net_berr),
  .bus_strobe(bus_strobe), .scsi_cs(scsi_cs), .irq_level(irq_level),
  .irq_pend(irq_pend), .en_v(en), .berr_lvl(lvl[1]), .berr_stat(stat_berr)
);

// File: tb/sim_periph_irq_ctrl.sv
module sim_periph_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic reg_sel = 0, reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic net_int = 0, net_berr = 0, scsi_irq_n = 1, bus_strobe = 0;
  logic [31:0] bus_addr = 0;
  logic scsi_cs, irq_pend;
  logic [2:0] irq_level;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  periph_irq_ctrl u0 (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [2:0] exp_lvl(logic [7:0] c0, logic [7:0] c1, logic [7:0] c2,
                                         logic a0, logic a1, logic a2);
    logic [2:0] m = 0;
    if (c0[4] && a0 && c0[2:0] > m) m = c0[2:0];
    if (c1[4] && a1 && c1[2:0] > m) m = c1[2:0];
    if (c2[4] && a2 && c2[2:0] > m) m = c2[2:0];
    return m;
  endfunction

  function automatic logic exp_cs(logic s, logic [31:0] a);
    return s && (a[31:12] == 20'hFFF47);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] c [3];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 4; i++) begin rd(i[1:0], d); chk("R1 rdata", d, 0); end
    chk("R1 pend", irq_pend, 0);
    chk("R1 level", irq_level, 0);

    // R2 register fields
    wr(0, 8'hDF); rd(0, d); chk("R2 reg0", d, 8'h17);
    wr(1, 8'h15); rd(1, d); chk("R2 reg1", d, 8'h15);
    wr(2, 8'h06); rd(2, d); chk("R2 reg2", d, 8'h06);
    wr(3, 8'hFF); rd(3, d); chk("R2 reg3", d, 8'h00);

    // R3 edge timing, R7 enabled src 0 level 7
    @(negedge clk); net_int = 1;
    @(negedge clk); @(negedge clk);
    rd(0, d); chk("R3 before third edge", d[5], 0);
    @(negedge clk);
    rd(0, d); chk("R3 set", d[5], 1);
    chk("R8 level", irq_level, 7);
    chk("R8 pend", irq_pend, 1);
    // R4 write 0 to bit5 leaves it, write 1 clears; held-high pin does not reset
    wr(0, 8'h17); rd(0, d); chk("R4 keep", d[5], 1);
    wr(0, 8'h37); rd(0, d); chk("R4 clear", d[5], 0);
    repeat (4) @(negedge clk);
    rd(0, d); chk("R3 held high no reset", d[5], 0);
    net_int = 0; repeat (4) @(negedge clk);
    rd(0, d); chk("R3 falling no set", d[5], 0);
    chk("R8 no src", irq_pend, 0);

    // R5 berr pulse, sticky; R7 reg1 enabled level 5
    net_berr = 1; @(negedge clk); net_berr = 0;
    rd(1, d); chk("R5 set", d[5], 1);
    chk("R5 level", irq_level, 5);
    repeat (5) @(negedge clk);
    rd(1, d); chk("R5 sticky", d[5], 1);
    // R10 clear and set same cycle
    reg_sel = 1; reg_wr = 1; reg_addr = 1; reg_wdata = 8'h35; net_berr = 1;
    @(negedge clk); reg_sel = 0; reg_wr = 0; net_berr = 0;
    rd(1, d); chk("R10 set wins", d[5], 1);
    wr(1, 8'h35); rd(1, d); chk("R4 clear berr", d[5], 0);

    // R6 scsi level; reg2 disabled level 6
    scsi_irq_n = 0; @(negedge clk);
    rd(2, d); chk("R6 one edge", d[5], 0);
    @(negedge clk);
    rd(2, d); chk("R6 active", d[5], 1);
    chk("R7 disabled no req", irq_pend, 0);
    wr(2, 8'h10); chk("R8 level zero no req", irq_pend, 0);
    wr(2, 8'h16); chk("R7 enabled req", irq_level, 6);
    scsi_irq_n = 1; repeat (2) @(negedge clk);
    rd(2, d); chk("R6 follows pin", d[5], 0);
    chk("R6 req drop", irq_pend, 0);

    // R9 directed
    bus_strobe = 1; bus_addr = 32'hFFF47000; #1; chk("R9 base", scsi_cs, 1);
    bus_addr = 32'hFFF47FFC; #1; chk("R9 top", scsi_cs, 1);
    bus_addr = 32'hFFF48000; #1; chk("R9 above", scsi_cs, 0);
    bus_addr = 32'hFFF46FFF; #1; chk("R9 below", scsi_cs, 0);
    bus_strobe = 0; bus_addr = 32'hFFF47010; #1; chk("R9 no strobe", scsi_cs, 0);

    // random: R8 priority, R3/R5/R6 status, R9 decode
    for (int it = 0; it < 60; it++) begin
      logic f0, f1, f2;
      for (int i = 0; i < 3; i++) begin
        c[i] = {3'b001, 1'($urandom), 1'b0, 3'($urandom)};
        wr(i[1:0], c[i]);
        c[i][5] = 0;
      end
      f0 = 1'($urandom); f1 = 1'($urandom); f2 = 1'($urandom);
      @(negedge clk);
      net_int = f0; scsi_irq_n = !f2; net_berr = f1;
      @(negedge clk); net_berr = 0;
      repeat (3) @(negedge clk);
      rd(0, d); chk("R3 rand stat", d[5], f0);
      rd(1, d); chk("R5 rand stat", d[5], f1);
      rd(2, d); chk("R6 rand stat", d[5], f2);
      chk("R8 rand level", irq_level, exp_lvl(c[0], c[1], c[2], f0, f1, f2));
      chk("R8 rand pend", irq_pend, exp_lvl(c[0], c[1], c[2], f0, f1, f2) != 0);
      for (int k = 0; k < 3; k++) begin
        bus_strobe = 1'($urandom);
        bus_addr = $urandom;
        if ($urandom % 2) bus_addr[31:12] = 20'hFFF47;
        #1; chk("R9 rand", scsi_cs, exp_cs(bus_strobe, bus_addr));
      end
      net_int = 0; scsi_irq_n = 1;
      repeat (3) @(negedge clk);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule